// File: doc/BRIEF.md
# Bus Line Monitor with Idle Timer

This block watches four slow external lines: the clock and data lines of a two-wire serial bus, a general-purpose control line and an active-low alert line. Each line passes through a synchronizer, and the synchronized level is presented on its own raw output so firmware can sample the pins safely. Edge detectors feed two sticky flags. One flag catches an edge on the control line, and a configuration input selects whether that edge is rising or falling. The other flag catches a falling edge on the alert line. Each flag stays set until firmware pulses its clear input.

An idle timer runs alongside the edge logic. Whenever the synchronized clock and data lines are both high, the timer counts internal clock cycles. Once the count reaches a threshold it raises a bus-free indication. The threshold is derived from the clock frequency and an idle time in nanoseconds, with a nominal 50 µs by default. A low level on either line clears the indication and restarts the count. The block has no data stream, so every pin is a plain level signal.

All four lines are expected to be high (released) while reset is held. The synchronizer and history registers reset to that level.

Top module: `bmon_line_monitor`

## Requirements
- R1: Each raw output (`scl_raw`, `sda_raw`, `ctrl_raw`, `alert_raw`) follows its pin, rising and falling, 2 clock edges after the pin changes (SYNC_STAGES = 2).
- R2: During reset and just after it, all raw outputs are 1, both edge flags are 0 and `bus_free` is 0.
- R3: With `ctrl_rise_sel` = 1, a rising edge on `ctrl_i` sets `ctrl_edge` on the 3rd clock edge after the pin change, and a falling edge leaves it clear.
- R4: With `ctrl_rise_sel` = 0, a falling edge on `ctrl_i` sets `ctrl_edge` on the 3rd clock edge after the pin change, and a rising edge leaves it clear.
- R5: A falling edge on `alert_i` sets `alert_edge` on the 3rd clock edge after the pin change, and a rising edge leaves it clear.
- R6: An edge flag, once set, holds 1 until its clear input is high at a clock edge. It reads 0 after that edge.
- R7: If a clear pulse meets a new qualifying edge in the same clock, the flag stays 1.
- R8: `bus_free` rises IDLE_CYCLES clock edges after both synchronized lines are high. Measured from the later pin rising, that is 2 + IDLE_CYCLES edges.
- R9: A low level on `scl_i` or `sda_i` lasting at least one clock clears `bus_free` on the 3rd clock edge after the pin falls, and restarts the idle count from zero.
- R10: IDLE_CYCLES = CLK_MHZ × IDLE_NS / 1000, with a minimum of 1. The default is 250 MHz and 50000 ns, giving 12500 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line pin (asynchronous) |
| sda_i | input | 1 | Bus data line pin (asynchronous) |
| ctrl_i | input | 1 | Control line pin (asynchronous) |
| alert_i | input | 1 | Alert line pin, active low (asynchronous) |
| ctrl_rise_sel | input | 1 | 1: control flag on rising edge, 0: on falling edge |
| ctrl_edge_clr | input | 1 | Clear pulse for the control edge flag |
| alert_edge_clr | input | 1 | Clear pulse for the alert edge flag |
| scl_raw | output | 1 | Synchronized clock line level |
| sda_raw | output | 1 | Synchronized data line level |
| ctrl_raw | output | 1 | Synchronized control line level |
| alert_raw | output | 1 | Synchronized alert line level |
| ctrl_edge | output | 1 | Sticky control edge flag |
| alert_edge | output | 1 | Sticky alert falling-edge flag |
| bus_free | output | 1 | Both bus lines have been high for the idle time |

## Verification
Each result has a fixed latency, counted in clock edges from the pin change:
- raw levels: 2 edges
- edge flags: 3 edges
- `bus_free` falling: 3 edges
- `bus_free` rising: 2 + IDLE_CYCLES edges

The bench drives pins just after a falling clock edge and samples at later falling edges, each a known number of rising edges after the stimulus. The idle-timer sweep checks `bus_free` at every falling edge across each low pulse and the full recovery window. This pins down both the cycle the indication drops and the exact cycle it returns. The edge sweeps check every pairing of start level, end level and polarity select at the 3-edge point.

// File: rtl/bmon_pkg.sv
package bmon_pkg;

  localparam int unsigned NUM_LINES = 4;

  typedef enum logic [1:0] {
    LN_SCL   = 2'd0,
    LN_SDA   = 2'd1,
    LN_CTRL  = 2'd2,
    LN_ALERT = 2'd3
  } line_idx_e;

  // Idle threshold in clock cycles from clock MHz and idle nanoseconds (R10)
  function automatic int unsigned idle_cycles(input int unsigned clk_mhz,
                                              input int unsigned idle_ns);
    longint unsigned prod;
    prod = longint'(clk_mhz) * longint'(idle_ns) / 64'd1000;
    if (prod < 64'd1) prod = 64'd1;
    return int'(prod);
  endfunction

endpackage

// File: rtl/bmon_sync.sv
module bmon_sync #(
  parameter int unsigned           WIDTH     = 4,
  parameter int unsigned           STAGES    = 2,
  parameter logic [WIDTH-1:0]      RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stg[s] <= RESET_VAL;
        else        stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stg[s] <= RESET_VAL;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/bmon_edge_flag.sv
module bmon_edge_flag #(
  parameter logic RST_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic rise_en,
  input  logic fall_en,
  input  logic clr,
  output logic flag
);

  logic prev;
  logic hit;

  assign hit = (rise_en & level & ~prev) | (fall_en & ~level & prev);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev <= RST_LEVEL;
      flag <= 1'b0;
    end else begin
      prev <= level;
      flag <= hit | (flag & ~clr);
    end
  end

  // R6: a set flag with no clear stays set
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);

  // R6: a clear with no new edge drops the flag
  p_flag_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && (level == prev)) |=> !flag);

  // R3/R4/R5: a flag only rises after a level change of the enabled direction
  p_flag_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> (($past(level) != $past(level, 2)) &&
                     ($past(level) ? $past(rise_en) : $past(fall_en))));

endmodule

// File: rtl/bmon_idle_timer.sv
module bmon_idle_timer #(
  parameter int unsigned IDLE_CYCLES = 12500,
  localparam int unsigned CW         = $clog2(IDLE_CYCLES + 1),
  localparam logic [CW-1:0] LAST     = CW'(IDLE_CYCLES - 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic bus_free
);

  logic [CW-1:0] cnt;
  logic          both_hi;

  assign both_hi = scl & sda;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      bus_free <= 1'b0;
    end else if (!both_hi) begin
      cnt      <= '0;
      bus_free <= 1'b0;
    end else if (!bus_free) begin
      if (cnt == LAST) bus_free <= 1'b1;
      else             cnt      <= cnt + 1'b1;
    end
  end

  // R9: any low synchronized line drops bus_free on the next edge
  p_free_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl && sda) |=> !bus_free);

  // R8: bus_free only rises after both lines were high
  p_free_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_free) |-> $past(scl && sda));

  // R8: idle count never passes its threshold
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R9: count restarts at zero after a low line
  p_cnt_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl && sda) |=> (cnt == '0));

endmodule

// File: rtl/bmon_line_monitor.sv
module bmon_line_monitor #(
  parameter int unsigned CLK_MHZ     = 250,
  parameter int unsigned IDLE_NS     = 50000,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned IDLE_CYCLES = bmon_pkg::idle_cycles(CLK_MHZ, IDLE_NS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic ctrl_i,
  input  logic alert_i,
  input  logic ctrl_rise_sel,
  input  logic ctrl_edge_clr,
  input  logic alert_edge_clr,
  output logic scl_raw,
  output logic sda_raw,
  output logic ctrl_raw,
  output logic alert_raw,
  output logic ctrl_edge,
  output logic alert_edge,
  output logic bus_free
);

  import bmon_pkg::*;

  logic [NUM_LINES-1:0] pins;
  logic [NUM_LINES-1:0] synced;

  assign pins[LN_SCL]   = scl_i;
  assign pins[LN_SDA]   = sda_i;
  assign pins[LN_CTRL]  = ctrl_i;
  assign pins[LN_ALERT] = alert_i;

  bmon_sync #(
    .WIDTH     (NUM_LINES),
    .STAGES    (SYNC_STAGES),
    .RESET_VAL ({NUM_LINES{1'b1}})
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pins),
    .q     (synced)
  );

  assign scl_raw   = synced[LN_SCL];
  assign sda_raw   = synced[LN_SDA];
  assign ctrl_raw  = synced[LN_CTRL];
  assign alert_raw = synced[LN_ALERT];

  // Control line: polarity from ctrl_rise_sel (R3, R4)
  bmon_edge_flag #(.RST_LEVEL(1'b1)) u_ctrl_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .level   (synced[LN_CTRL]),
    .rise_en (ctrl_rise_sel),
    .fall_en (~ctrl_rise_sel),
    .clr     (ctrl_edge_clr),
    .flag    (ctrl_edge)
  );

  // Alert line: falling edge only (R5)
  bmon_edge_flag #(.RST_LEVEL(1'b1)) u_alert_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .level   (synced[LN_ALERT]),
    .rise_en (1'b0),
    .fall_en (1'b1),
    .clr     (alert_edge_clr),
    .flag    (alert_edge)
  );

  bmon_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl      (synced[LN_SCL]),
    .sda      (synced[LN_SDA]),
    .bus_free (bus_free)
  );

  // R5: alert flag never rises right after a rising alert level
  p_alert_fall_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert_edge) |-> !$past(alert_raw));

  // R2: outputs in reset state while reset is held
  p_reset_state_r2: assert property (@(posedge clk)
    !rst_n |=> (!ctrl_edge && !alert_edge && !bus_free && scl_raw && sda_raw));

endmodule

// File: tb/bmon_line_monitor_tb_top.sv
module bmon_line_monitor_tb_top;

  localparam int unsigned T_MHZ  = 250;
  localparam int unsigned T_NS   = 200;
  localparam int unsigned T_IDLE = T_MHZ * T_NS / 1000;  // R10: 50 cycles

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_i = 1'b1, sda_i = 1'b1, ctrl_i = 1'b1, alert_i = 1'b1;
  logic ctrl_rise_sel = 1'b1, ctrl_edge_clr = 1'b0, alert_edge_clr = 1'b0;
  logic scl_raw, sda_raw, ctrl_raw, alert_raw, ctrl_edge, alert_edge, bus_free;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  bmon_line_monitor #(.CLK_MHZ(T_MHZ), .IDLE_NS(T_NS)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .scl_i(scl_i), .sda_i(sda_i), .ctrl_i(ctrl_i), .alert_i(alert_i),
    .ctrl_rise_sel(ctrl_rise_sel), .ctrl_edge_clr(ctrl_edge_clr),
    .alert_edge_clr(alert_edge_clr),
    .scl_raw(scl_raw), .sda_raw(sda_raw), .ctrl_raw(ctrl_raw),
    .alert_raw(alert_raw), .ctrl_edge(ctrl_edge), .alert_edge(alert_edge),
    .bus_free(bus_free)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic got, input logic exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic clr_ctrl();
    ctrl_edge_clr = 1'b1; tick(1); ctrl_edge_clr = 1'b0;
  endtask

  task automatic clr_alert();
    alert_edge_clr = 1'b1; tick(1); alert_edge_clr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    tick(3);
    rst_n = 1'b1;
    // R2: state right after reset release
    chk("R2 scl_raw", scl_raw, 1'b1);
    chk("R2 sda_raw", sda_raw, 1'b1);
    chk("R2 ctrl_raw", ctrl_raw, 1'b1);
    chk("R2 alert_raw", alert_raw, 1'b1);
    chk("R2 ctrl_edge", ctrl_edge, 1'b0);
    chk("R2 alert_edge", alert_edge, 1'b0);
    chk("R2 bus_free", bus_free, 1'b0);
    // R8/R10: lines high since reset -> free after T_IDLE edges
    tick(T_IDLE - 1);
    chk("R8 free not yet", bus_free, 1'b0);
    tick(1);
    chk("R8 free at threshold", bus_free, 1'b1);

    // R1: raw follows each pin both directions at exactly 2 edges
    for (int ln = 0; ln < 4; ln++) begin
      for (int v = 0; v < 2; v++) begin
        logic lvl;
        lvl = (v == 0) ? 1'b0 : 1'b1;
        case (ln)
          0: scl_i = lvl; 1: sda_i = lvl; 2: ctrl_i = lvl; default: alert_i = lvl;
        endcase
        tick(1);
        case (ln)
          0: chk("R1 scl early", scl_raw, ~lvl);
          1: chk("R1 sda early", sda_raw, ~lvl);
          2: chk("R1 ctrl early", ctrl_raw, ~lvl);
          default: chk("R1 alert early", alert_raw, ~lvl);
        endcase
        tick(1);
        case (ln)
          0: chk("R1 scl", scl_raw, lvl);
          1: chk("R1 sda", sda_raw, lvl);
          2: chk("R1 ctrl", ctrl_raw, lvl);
          default: chk("R1 alert", alert_raw, lvl);
        endcase
        tick(2);
      end
    end
    tick(2);
    clr_ctrl(); clr_alert(); tick(1);

    // R3/R4: sweep polarity x start level x end level
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < 2; a++) begin
        for (int b = 0; b < 2; b++) begin
          ctrl_rise_sel = s[0];
          ctrl_i = a[0];
          tick(4);
          clr_ctrl();
          tick(1);
          chk(s ? "R3 pre" : "R4 pre", ctrl_edge, 1'b0);
          ctrl_i = b[0];
          tick(2);
          chk(s ? "R3 not early" : "R4 not early", ctrl_edge, 1'b0);
          tick(1);
          chk(s ? "R3 edge" : "R4 edge", ctrl_edge,
              (a != b) && (b[0] == s[0]));
        end
      end
    end

    // R5: alert falling sets, rising does not
    alert_i = 1'b1; tick(4); clr_alert(); tick(1);
    alert_i = 1'b0; tick(3);
    chk("R5 fall sets", alert_edge, 1'b1);
    tick(2); clr_alert(); tick(1);
    chk("R6 alert cleared", alert_edge, 1'b0);
    alert_i = 1'b1; tick(3);
    chk("R5 rise ignored", alert_edge, 1'b0);
    tick(5);
    chk("R5 rise ignored later", alert_edge, 1'b0);

    // R6: stickiness over many cycles, then clear
    ctrl_rise_sel = 1'b1; ctrl_i = 1'b0; tick(4); clr_ctrl(); tick(1);
    ctrl_i = 1'b1; tick(3);
    for (int k = 0; k < 10; k++) begin
      chk("R6 sticky", ctrl_edge, 1'b1);
      tick(1);
    end
    ctrl_edge_clr = 1'b1; tick(1); ctrl_edge_clr = 1'b0;
    chk("R6 clear", ctrl_edge, 1'b0);

    // R7: clear at the same edge as a new set
    ctrl_i = 1'b0; tick(4);
    ctrl_i = 1'b1; tick(2);
    ctrl_edge_clr = 1'b1; tick(1); ctrl_edge_clr = 1'b0;
    chk("R7 ctrl set wins", ctrl_edge, 1'b1);
    alert_i = 1'b0; tick(2);
    alert_edge_clr = 1'b1; tick(1); alert_edge_clr = 1'b0;
    chk("R7 alert set wins", alert_edge, 1'b1);
    alert_i = 1'b1;
    tick(T_IDLE + 4);

    // R8/R9: low pulses on each bus line, checked every cycle
    for (int ln = 0; ln < 2; ln++) begin
      for (int wi = 0; wi < 3; wi++) begin
        int w;
        w = (wi == 0) ? 1 : (wi == 1) ? 2 : 5;
        chk("R8 free before pulse", bus_free, 1'b1);
        if (ln == 0) scl_i = 1'b0; else sda_i = 1'b0;
        for (int k = 1; k <= w + T_IDLE + 4; k++) begin
          tick(1);
          if (k == w) begin
            if (ln == 0) scl_i = 1'b1; else sda_i = 1'b1;
          end
          chk((k < w + 2 + T_IDLE) ? "R9 free window" : "R8 free recovery",
              bus_free, (k < 3) || (k >= w + 2 + T_IDLE));
        end
      end
    end

    // R9: one line lows while the other is low too, restart from later rise
    scl_i = 1'b0; sda_i = 1'b0; tick(6);
    scl_i = 1'b1; tick(10);
    sda_i = 1'b1;
    for (int k = 1; k <= T_IDLE + 4; k++) begin
      tick(1);
      chk("R9 restart both", bus_free, k >= 2 + T_IDLE);
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule